// File: doc/BRIEF.md
# Postfix Stack Execution Core

This block executes a stream of fixed-width instructions in which every arithmetic operand is implicit. There is no register file. Values live on a small internal hardware stack. A memory-transfer instruction either copies a data word onto the top of the stack or moves the top entry out to a data address. The arithmetic instructions fold the two uppermost entries into one. A program for an expression is therefore written in postfix order: the operands come first, followed by the operator that consumes them.

The core fetches from an instruction memory read port and accesses a data memory through a combined read/write port. Both memories are synchronous and return read data one cycle after the address is presented. A `start` pulse begins execution at instruction address 0 with an empty stack. The core runs until it meets a stop instruction or an illegal stack access. At that point `halted` rises, and `fault` also rises if a stack limit was violated.

Top module: `pfx_stack_core`

## Requirements
- R1: While reset is held and after it is released, `halted`, `fault` and `dmem_we` are low, `imem_addr` is 0, and the core stays idle until `start` is seen.
- R2: A `start` pulse while idle or halted restarts fetch at address 0 with an empty stack. It clears `halted` and `fault` in the next cycle.
- R3: An instruction word carries the opcode in bits 15:12 and an address in bits 11:0. Codes are 0 = stop, 1 = load-to-stack, 2 = store-from-stack, 3 = add, 4 = multiply. Codes 5 to 15 change nothing and only advance the fetch address. The address field of codes other than 1 and 2 is ignored.
- R4: Code 1 places the data word at its address on top of the stack. Code 2 writes the top entry to its address with a single-cycle `dmem_we` pulse and removes that entry, so entries leave in reverse order of arrival.
- R5: Add and multiply remove the top two entries and push one 16-bit result. The sum wraps modulo 2^16, and the product keeps the low 16 bits of the full product of the two operands.
- R6: The eight-instruction postfix program for X*Y + W*U, ending with a store to Z, leaves the wrapped value X*Y + W*U at data address Z.
- R7: A load-to-stack while the stack already holds 8 entries sets `fault` and `halted` and performs no memory write.
- R8: A store-from-stack on an empty stack, or add or multiply with fewer than two entries, sets `fault` and `halted`, and no memory write takes place.
- R9: After a stop instruction `halted` is high, `fault` is low, and `imem_addr` no longer moves. This state holds until the next `start`.
- R10: Every instruction spends one fetch cycle, one decode cycle and one execute cycle. A load-to-stack instruction takes one further cycle to receive its data word. `imem_addr` always shows the address of the next instruction to fetch.
- R11: Once set, `fault` remains high until the next `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin execution at address 0 when idle or halted |
| imem_addr | output | ADDR_W (12) | Instruction fetch address |
| imem_rdata | input | OPC_W+ADDR_W (16) | Instruction word, valid one cycle after its address |
| dmem_addr | output | ADDR_W (12) | Data address taken from the current instruction |
| dmem_we | output | 1 | Data write strobe, one cycle per store |
| dmem_wdata | output | DATA_W (16) | Top-of-stack value being stored |
| dmem_rdata | input | DATA_W (16) | Data word, valid one cycle after its address |
| halted | output | 1 | Execution has stopped |
| fault | output | 1 | Sticky stack overflow or underflow indicator |

## Verification
Several properties are checked on every cycle. The stack occupancy never exceeds its depth. A write strobe only occurs with at least one entry present, lasts one cycle, and shrinks the stack by one. A fault always comes with the halted state. The halted state, the fault flag and the fetch address hold until a start pulse. The bench's scenarios and its per-cycle reference model cover the remaining behaviour. They show which values reach memory, the LIFO order of stores, wrapping arithmetic, ignored opcodes and address fields, exact instruction timing, and the clearing of a full stack on restart.

// File: rtl/pfx_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the postfix stack core.
// Assumes a 4-bit opcode field; other opcode widths cast these codes.
package pfx_pkg;

    // Opcode values (instruction bits 15:12 with default widths)
    localparam int OPC_STOP  = 0;
    localparam int OPC_LOAD  = 1;
    localparam int OPC_STORE = 2;
    localparam int OPC_ADD   = 3;
    localparam int OPC_MUL   = 4;

    // Controller sequence states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_LOAD,
        ST_HALT
    } core_st_e;

    // Stack update requests issued by the controller
    typedef enum logic [1:0] {
        SK_HOLD,
        SK_PUSH,
        SK_POP,
        SK_FOLD
    } stk_op_e;

endpackage

// File: rtl/pfx_stack.sv
`timescale 1ns/1ps
// Hardware LIFO of DEPTH words with occupancy tracking.
// Only the top entry (and the one below it, for folding) is visible.
// A fold replaces the top two entries by wdata. Requests that the
// current occupancy cannot honour are dropped; the controller is
// expected to flag them as faults. clear empties the stack.
module pfx_stack
    import pfx_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  stk_op_e           op,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] top,
    output logic [DATA_W-1:0] second,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              empty,
    output logic              has_two
);

    logic [DATA_W-1:0] slot [DEPTH];

    // Occupancy flags derived from the counter
    always_comb begin
        full    = (int'(count) == DEPTH);
        empty   = (count == '0);
        has_two = (int'(count) >= 2);
    end

    // Per-entry storage; each slot loads on a push or fold that lands on it
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin : p_slot
            if (!rst_n) begin
                slot[i] <= '0;
            end else if (op == SK_PUSH && !full && int'(count) == i) begin
                slot[i] <= wdata;
            end else if (op == SK_FOLD && has_two && int'(count) == i + 2) begin
                slot[i] <= wdata;
            end
        end
    end

    // Select the top and second entries from the occupancy
    always_comb begin
        top    = '0;
        second = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (int'(count) == k + 1) top = slot[k];
            if (int'(count) == k + 2) second = slot[k];
        end
    end

    // Occupancy counter update
    always_ff @(posedge clk) begin : p_count
        if (!rst_n || clear) begin
            count <= '0;
        end else begin
            case (op)
                SK_PUSH: if (!full)   count <= count + CNT_W'(1);
                SK_POP:  if (!empty)  count <= count - CNT_W'(1);
                SK_FOLD: if (has_two) count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/pfx_alu.sv
`timescale 1ns/1ps
// Two-operand arithmetic for the stack core: wrapping sum or the low
// DATA_W bits of the product. Purely combinational.
module pfx_alu #(
    parameter int DATA_W = 16
) (
    input  logic              mul_sel,
    input  logic [DATA_W-1:0] lhs,
    input  logic [DATA_W-1:0] rhs,
    output logic [DATA_W-1:0] res
);

    logic [DATA_W-1:0] sum;
    logic [DATA_W-1:0] prod_lo;

    // Both results at DATA_W width, then pick one
    always_comb begin
        sum     = lhs + rhs;
        prod_lo = lhs * rhs;
        res     = mul_sel ? prod_lo : sum;
    end

endmodule

// File: rtl/pfx_ctrl.sv
`timescale 1ns/1ps
// Sequencer of the stack core: fetch, decode, execute and, for a load,
// a data-return cycle. Checks stack limits in the execute cycle and
// stops with a sticky fault when one is violated. Assumes both memories
// return read data one cycle after the address.
module pfx_ctrl
    import pfx_pkg::*;
#(
    parameter int OPC_W  = 4,
    parameter int ADDR_W = 12,
    parameter int INSN_W = OPC_W + ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [INSN_W-1:0] insn_in,
    input  logic              stk_full,
    input  logic              stk_empty,
    input  logic              stk_has_two,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output stk_op_e           stk_op,
    output logic              stk_clear,
    output logic              load_sel,
    output logic              mul_sel,
    output logic              halted,
    output logic              fault
);

    core_st_e          st;
    logic [INSN_W-1:0] ir;
    logic [OPC_W-1:0]  opc;
    logic              op_stop, op_load, op_store, op_arith;
    logic              in_exec, bad;

    // Field split and opcode decode of the held instruction
    always_comb begin
        opc      = ir[INSN_W-1 -: OPC_W];
        mem_addr = ir[ADDR_W-1:0];
        op_stop  = (opc == OPC_W'(OPC_STOP));
        op_load  = (opc == OPC_W'(OPC_LOAD));
        op_store = (opc == OPC_W'(OPC_STORE));
        mul_sel  = (opc == OPC_W'(OPC_MUL));
        op_arith = (opc == OPC_W'(OPC_ADD)) || mul_sel;
        in_exec  = (st == ST_EXEC);
        bad      = in_exec && ((op_load && stk_full) ||
                               (op_store && stk_empty) ||
                               (op_arith && !stk_has_two));
    end

    // State, program counter, instruction and fault registers
    always_ff @(posedge clk) begin : p_seq
        if (!rst_n) begin
            st    <= ST_IDLE;
            pc    <= '0;
            ir    <= '0;
            fault <= 1'b0;
        end else begin
            case (st)
                ST_IDLE, ST_HALT: begin
                    if (start) begin
                        st    <= ST_FETCH;
                        pc    <= '0;
                        fault <= 1'b0;
                    end
                end
                ST_FETCH:  st <= ST_DECODE;
                ST_DECODE: begin
                    ir <= insn_in;
                    pc <= pc + ADDR_W'(1);
                    st <= ST_EXEC;
                end
                ST_EXEC: begin
                    if (op_stop) begin
                        st <= ST_HALT;
                    end else if (bad) begin
                        fault <= 1'b1;
                        st    <= ST_HALT;
                    end else if (op_load) begin
                        st <= ST_LOAD;
                    end else begin
                        st <= ST_FETCH;
                    end
                end
                ST_LOAD:   st <= ST_FETCH;
                default:   st <= ST_IDLE;
            endcase
        end
    end

    // Stack requests, write strobe and status for the current state
    always_comb begin
        stk_op = SK_HOLD;
        if (st == ST_LOAD) begin
            stk_op = SK_PUSH;
        end else if (in_exec && !bad) begin
            if (op_store)      stk_op = SK_POP;
            else if (op_arith) stk_op = SK_FOLD;
        end
        mem_we    = in_exec && op_store && !stk_empty;
        load_sel  = (st == ST_LOAD);
        stk_clear = start && (st == ST_IDLE || st == ST_HALT);
        halted    = (st == ST_HALT);
    end

endmodule

// File: rtl/pfx_stack_core.sv
`timescale 1ns/1ps
// Postfix stack execution core: fetches opcode/address words and runs
// them against an internal LIFO with implicit arithmetic operands.
// Assumes synchronous memories with one cycle of read latency.
module pfx_stack_core
    import pfx_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12,
    parameter int OPC_W  = 4,
    parameter int DEPTH  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    output logic [ADDR_W-1:0]       imem_addr,
    input  logic [OPC_W+ADDR_W-1:0] imem_rdata,
    output logic [ADDR_W-1:0]       dmem_addr,
    output logic                    dmem_we,
    output logic [DATA_W-1:0]       dmem_wdata,
    input  logic [DATA_W-1:0]       dmem_rdata,
    output logic                    halted,
    output logic                    fault
);

    localparam int INSN_W = OPC_W + ADDR_W;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    stk_op_e           stk_op;
    logic              stk_clear, load_sel, mul_sel;
    logic              stk_full, stk_empty, stk_has_two;
    logic [CNT_W-1:0]  stk_count;
    logic [DATA_W-1:0] stk_top, stk_second, alu_res, push_val;

    pfx_ctrl #(
        .OPC_W (OPC_W),
        .ADDR_W(ADDR_W),
        .INSN_W(INSN_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .insn_in    (imem_rdata),
        .stk_full   (stk_full),
        .stk_empty  (stk_empty),
        .stk_has_two(stk_has_two),
        .pc         (imem_addr),
        .mem_addr   (dmem_addr),
        .mem_we     (dmem_we),
        .stk_op     (stk_op),
        .stk_clear  (stk_clear),
        .load_sel   (load_sel),
        .mul_sel    (mul_sel),
        .halted     (halted),
        .fault      (fault)
    );

    pfx_alu #(
        .DATA_W(DATA_W)
    ) u_alu (
        .mul_sel(mul_sel),
        .lhs    (stk_second),
        .rhs    (stk_top),
        .res    (alu_res)
    );

    // Value written into the stack: returned data word or arithmetic result
    always_comb begin
        push_val   = load_sel ? dmem_rdata : alu_res;
        dmem_wdata = stk_top;
    end

    pfx_stack #(
        .DATA_W(DATA_W),
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_stack (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (stk_clear),
        .op     (stk_op),
        .wdata  (push_val),
        .top    (stk_top),
        .second (stk_second),
        .count  (stk_count),
        .full   (stk_full),
        .empty  (stk_empty),
        .has_two(stk_has_two)
    );

endmodule

// File: rtl/pfx_stack_core_chk.sv
`timescale 1ns/1ps
// Property checker for pfx_stack_core, attached by bind below.
// Observes the top-level ports and the stack occupancy.
module pfx_stack_core_chk #(
    parameter int ADDR_W = 12,
    parameter int DEPTH  = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              halted,
    input  logic              fault,
    input  logic              dmem_we,
    input  logic [ADDR_W-1:0] imem_addr,
    input  logic [CNT_W-1:0]  stk_count
);

    // R1: reset leaves the core quiet
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!halted && !fault && !dmem_we));

    // R2: a start while stopped resumes with flags cleared
    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && start) |=> (!halted && !fault));

    // R4: store strobe lasts one cycle
    a_r4_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |=> !dmem_we);

    // R4: a store removes exactly one entry
    a_r4_store_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |=> (stk_count == $past(stk_count) - CNT_W'(1)));

    // R7: occupancy never passes the depth
    a_r7_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(stk_count) <= DEPTH);

    // R7: a fault is always accompanied by the halted state
    a_r7_fault_halts: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> halted);

    // R8: no write strobe from an empty stack
    a_r8_no_empty_store: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> (stk_count != '0));

    // R9: halted holds without a start
    a_r9_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !start) |=> halted);

    // R9: fetch address frozen while halted
    a_r9_fetch_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !start) |=> $stable(imem_addr));

    // R11: fault persists until a start
    a_r11_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !start) |=> fault);

endmodule

bind pfx_stack_core pfx_stack_core_chk #(
    .ADDR_W(ADDR_W),
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .halted   (halted),
    .fault    (fault),
    .dmem_we  (dmem_we),
    .imem_addr(imem_addr),
    .stk_count(stk_count)
);

// File: tb/pfx_stack_core_test.sv
`timescale 1ns/1ps
// Bench for pfx_stack_core: behavioural reference model compared each
// cycle, plus scenario checks on memory contents and flags.
module pfx_stack_core_test;

    localparam int PH_IDLE = 0, PH_FETCH = 1, PH_DEC = 2,
                   PH_EXEC = 3, PH_LOAD = 4, PH_HALT = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] imem_addr, dmem_addr;
    logic [15:0] imem_q, dmem_q, dmem_wdata;
    logic        dmem_we, halted, fault;

    logic [15:0] imem [256];
    logic [15:0] dmem [256];
    logic        ld_i = 1'b0, ld_d = 1'b0;
    logic [7:0]  ld_a = '0;
    logic [15:0] ld_w = '0;

    int n_chk = 0, n_fail = 0, cyc_chk = 0, cyc_fail = 0;
    int ncyc;

    always #2.5 clk = ~clk;

    pfx_stack_core uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .imem_addr (imem_addr),
        .imem_rdata(imem_q),
        .dmem_addr (dmem_addr),
        .dmem_we   (dmem_we),
        .dmem_wdata(dmem_wdata),
        .dmem_rdata(dmem_q),
        .halted    (halted),
        .fault     (fault)
    );

    // Synchronous memories with a loading path for the bench
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 256; k++) begin
                imem[k] <= '0;
                dmem[k] <= '0;
            end
        end else begin
            if (ld_i) imem[ld_a] <= ld_w;
            if (ld_d) dmem[ld_a] <= ld_w;
            else if (dmem_we) dmem[dmem_addr[7:0]] <= dmem_wdata;
        end
        imem_q <= imem[imem_addr[7:0]];
        dmem_q <= dmem[dmem_addr[7:0]];
    end

    // Reference model
    int          m_ph = PH_IDLE;
    int          m_pc = 0;
    logic [15:0] m_ir = '0;
    logic        m_fault = 1'b0;
    logic        m_live = 1'b0;
    logic [15:0] m_stk [$];
    logic [15:0] m_a, m_b;

    always @(posedge clk) begin
        m_live = rst_n;
        if (!rst_n) begin
            m_ph = PH_IDLE; m_pc = 0; m_ir = '0; m_fault = 1'b0;
            m_stk.delete();
        end else begin
            case (m_ph)
                PH_IDLE, PH_HALT: if (start) begin
                    m_ph = PH_FETCH; m_pc = 0; m_fault = 1'b0;
                    m_stk.delete();
                end
                PH_FETCH: m_ph = PH_DEC;
                PH_DEC: begin
                    m_ir = imem[m_pc[7:0]];
                    m_pc = (m_pc + 1) & 'hFFF;
                    m_ph = PH_EXEC;
                end
                PH_EXEC: begin
                    case (int'(m_ir[15:12]))
                        0: m_ph = PH_HALT;
                        1: if (m_stk.size() >= 8) begin m_fault = 1'b1; m_ph = PH_HALT; end
                           else m_ph = PH_LOAD;
                        2: if (m_stk.size() == 0) begin m_fault = 1'b1; m_ph = PH_HALT; end
                           else begin void'(m_stk.pop_back()); m_ph = PH_FETCH; end
                        3, 4: if (m_stk.size() < 2) begin m_fault = 1'b1; m_ph = PH_HALT; end
                           else begin
                               m_b = m_stk.pop_back();
                               m_a = m_stk.pop_back();
                               m_stk.push_back(m_ir[15:12] == 4'd4 ? 16'(m_a * m_b) : 16'(m_a + m_b));
                               m_ph = PH_FETCH;
                           end
                        default: m_ph = PH_FETCH;
                    endcase
                end
                PH_LOAD: begin
                    m_stk.push_back(dmem[m_ir[7:0]]);
                    m_ph = PH_FETCH;
                end
                default: m_ph = PH_IDLE;
            endcase
        end
    end

    // Per-cycle comparison of outputs with the model
    logic exp_we;
    always @(negedge clk) begin
        if (rst_n && m_live) begin
            exp_we = (m_ph == PH_EXEC) && (m_ir[15:12] == 4'd2) && (m_stk.size() > 0);
            cyc_chk += 4;
            if (halted !== (m_ph == PH_HALT)) begin
                cyc_fail++;
                $display("FAIL R9 halted actual=%0b expected=%0b", halted, (m_ph == PH_HALT));
            end
            if (fault !== m_fault) begin
                cyc_fail++;
                $display("FAIL R11 fault actual=%0b expected=%0b", fault, m_fault);
            end
            if (imem_addr !== 12'(m_pc)) begin
                cyc_fail++;
                $display("FAIL R10 imem_addr actual=%0h expected=%0h", imem_addr, m_pc);
            end
            if (dmem_we !== exp_we) begin
                cyc_fail++;
                $display("FAIL R4 dmem_we actual=%0b expected=%0b", dmem_we, exp_we);
            end
            if (exp_we) begin
                cyc_chk += 2;
                if (dmem_addr !== m_ir[11:0]) begin
                    cyc_fail++;
                    $display("FAIL R4 dmem_addr actual=%0h expected=%0h", dmem_addr, m_ir[11:0]);
                end
                if (dmem_wdata !== m_stk[$]) begin
                    cyc_fail++;
                    $display("FAIL R4 dmem_wdata actual=%0h expected=%0h", dmem_wdata, m_stk[$]);
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ins(input int op, input int a);
        return {4'(op), 12'(a)};
    endfunction

    task automatic put_i(input int a, input logic [15:0] w);
        ld_i = 1'b1; ld_a = 8'(a); ld_w = w;
        @(negedge clk);
        ld_i = 1'b0;
    endtask

    task automatic put_d(input int a, input logic [15:0] w);
        ld_d = 1'b1; ld_a = 8'(a); ld_w = w;
        @(negedge clk);
        ld_d = 1'b0;
    endtask

    // Pulse start and count negedges until halted (state cycles + 1)
    task automatic run(output int cyc);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        chk("R2 halted cleared by start", {31'd0, halted}, 0);
        chk("R2 fault cleared by start", {31'd0, fault}, 0);
        while (!halted && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic finish_up();
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk + cyc_chk, n_fail + cyc_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        logic [11:0] frozen;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state and idling
        chk("R1 halted after reset", {31'd0, halted}, 0);
        chk("R1 fault after reset", {31'd0, fault}, 0);
        chk("R1 dmem_we after reset", {31'd0, dmem_we}, 0);
        chk("R1 imem_addr after reset", {20'd0, imem_addr}, 0);
        repeat (5) @(negedge clk);
        chk("R1 still idle without start", {31'd0, halted}, 0);

        // R6/R3: postfix expression with an unused opcode and stray address fields
        put_d(10, 16'd3); put_d(11, 16'd7); put_d(12, 16'hFFFE); put_d(13, 16'd5);
        put_d(8'hBC, 16'h0BAD);
        put_i(0, ins(1, 10)); put_i(1, ins(1, 11)); put_i(2, 16'h7ABC);
        put_i(3, ins(4, 'h455)); put_i(4, ins(1, 12)); put_i(5, ins(1, 13));
        put_i(6, ins(4, 0)); put_i(7, ins(3, 'hFFF)); put_i(8, ins(2, 20));
        put_i(9, ins(0, 'h123));
        run(ncyc);
        chk("R6 X*Y+W*U stored", {16'd0, dmem[20]}, 32'd11);
        chk("R3 unused opcode wrote nothing", {16'd0, dmem[8'hBC]}, 32'h0BAD);
        chk("R9 halted after stop", {31'd0, halted}, 1);
        chk("R9 no fault after stop", {31'd0, fault}, 0);
        chk("R10 cycles for program", ncyc, 35);
        frozen = imem_addr;
        repeat (6) @(negedge clk);
        chk("R9 fetch frozen", {20'd0, imem_addr}, {20'd0, frozen});
        chk("R9 halted held", {31'd0, halted}, 1);

        // R5/R4: wrapping arithmetic and LIFO store order
        put_d(30, 16'h7FFF); put_d(31, 16'h0001); put_d(32, 16'h0100);
        put_d(33, 16'hFFFF); put_d(34, 16'hFFFD); put_d(35, 16'h0007);
        put_d(36, 16'hAAAA); put_d(37, 16'h5555);
        put_i(0, ins(1, 30)); put_i(1, ins(1, 31)); put_i(2, ins(3, 0)); put_i(3, ins(2, 40));
        put_i(4, ins(1, 32)); put_i(5, ins(1, 32)); put_i(6, ins(4, 0)); put_i(7, ins(2, 41));
        put_i(8, ins(1, 33)); put_i(9, ins(1, 33)); put_i(10, ins(4, 0)); put_i(11, ins(2, 42));
        put_i(12, ins(1, 34)); put_i(13, ins(1, 35)); put_i(14, ins(4, 0)); put_i(15, ins(2, 43));
        put_i(16, ins(1, 36)); put_i(17, ins(1, 37)); put_i(18, ins(2, 44)); put_i(19, ins(2, 45));
        put_i(20, ins(0, 0));
        run(ncyc);
        chk("R5 sum wraps", {16'd0, dmem[40]}, 32'h8000);
        chk("R5 product low bits zero", {16'd0, dmem[41]}, 32'h0000);
        chk("R5 minus one squared", {16'd0, dmem[42]}, 32'h0001);
        chk("R5 signed product", {16'd0, dmem[43]}, 32'hFFEB);
        chk("R4 last in stored first", {16'd0, dmem[44]}, 32'h5555);
        chk("R4 first in stored last", {16'd0, dmem[45]}, 32'hAAAA);
        chk("R4 no fault", {31'd0, fault}, 0);

        // R7: ninth load overflows
        put_d(50, 16'h0042);
        for (int k = 0; k < 9; k++) put_i(k, ins(1, 50));
        put_i(9, ins(0, 0));
        run(ncyc);
        chk("R7 fault on overflow", {31'd0, fault}, 1);
        chk("R7 halted on overflow", {31'd0, halted}, 1);
        chk("R7 overflow timing", ncyc, 36);
        repeat (10) @(negedge clk);
        chk("R11 fault sticky", {31'd0, fault}, 1);

        // R8/R2: store on empty stack (restart must have emptied the full stack)
        put_d(60, 16'h1234);
        put_i(0, ins(2, 60)); put_i(1, ins(0, 0));
        run(ncyc);
        chk("R8 fault on empty store", {31'd0, fault}, 1);
        chk("R8 empty store wrote nothing", {16'd0, dmem[60]}, 32'h1234);
        chk("R2 restart emptied stack", ncyc, 4);

        // R8: add with one entry
        put_i(0, ins(1, 60)); put_i(1, ins(3, 60)); put_i(2, ins(2, 61)); put_i(3, ins(0, 0));
        run(ncyc);
        chk("R8 fault on short add", {31'd0, fault}, 1);
        chk("R8 short add wrote nothing", {16'd0, dmem[61]}, 32'h0000);

        // R8: multiply on empty stack
        put_i(0, ins(4, 0));
        run(ncyc);
        chk("R8 fault on empty multiply", {31'd0, fault}, 1);
        chk("R8 empty multiply timing", ncyc, 4);

        // R2: a clean rerun after faults
        put_i(0, ins(1, 10)); put_i(1, ins(2, 62)); put_i(2, ins(0, 0));
        run(ncyc);
        chk("R2 rerun clean", {31'd0, fault}, 0);
        chk("R2 rerun result", {16'd0, dmem[62]}, 32'd3);

        repeat (3) @(negedge clk);
        finish_up();
    end

endmodule